// File: doc/BRIEF.md
# Dashed Line Address Engine

The engine walks a straight line between two pixel coordinates on a one-bit-per-pixel plane and turns it into a stream of byte-wide raster requests. Each pixel becomes a byte address and a bit position. Pixels that share a byte are merged into one request. The request carries a write-protect mask in which a 0 marks a pixel that the downstream raster unit may modify. A 16-bit dash pattern, rotated once per plotted pixel, decides which pixels are released. The raster operation itself happens downstream.

Software loads the endpoints, the dash pattern and a plane offset through a byte-wide register port. A write to the go selector starts the line. The engine first runs a serial division to get the fixed-point minor-axis slope. It then steps one pixel per cycle. It pauses whenever a finished byte waits for its acknowledge. Screen width, height and the resolution mode come in as static pins.

Top module: `dash_line_engine`

## Requirements
- R1: After reset, busy_o and op_req_o are low, and all loaded registers (endpoints, pattern, offset) read as zero when a line is started.
- R2: Register selectors are 0 offset-low, 1 offset-high, 2 pattern bits 7:0, 3 pattern bits 15:8, 4/5 start X low/high, 6/7 start Y low/high, 8/9 end X low/high, 10/11 end Y low/high, and 15 go. An X high write keeps only data bits 1:0 (X bits 9:8). A Y high write keeps only data bit 0 (Y bit 8).
- R3: A pixel (x, y) maps to byte address y*W + floor(x/8) + offset, where W is width_i (the screen width in units of 8 pixels). The offset is a 14-bit value whose bit 0 is zero, bits 8:1 come from the offset-low data, and bits 13:9 come from offset-high data bits 4:0.
- R4: With hires_i high the address keeps 15 bits. With hires_i low it keeps 14 bits, so op_addr_o bit 14 is 0.
- R5: The major axis is the one with the larger absolute delta (X on a tie). It steps by one toward the end point for each pixel, over |major|+1 pixels. A 16-bit accumulator starting at 0 adds floor(|minor|*32768/|major|) after each pixel. Each time it reaches 32768, the minor coordinate steps by one toward the end and 32768 is subtracted.
- R6: A pixel with x mod 8 = k owns mask bit 7-k. That bit is cleared only if pattern bit 15 is 1 when the pixel is plotted. The pattern rotates left by one after every plotted pixel. Each line starts from the loaded pattern.
- R7: Consecutive pixels with the same byte address form one request. Its mask starts at 0xFF. The request is issued when a pixel with a different address arrives, and when the line ends.
- R8: The first pixel with x >= 8*W or y >= height_i ends the line. That pixel and all later ones are not plotted, and the pending byte is still issued.
- R9: op_req_o stays high with op_addr_o and op_mask_o unchanged until op_ack_i is sampled high. It then drops for at least one cycle.
- R10: busy_o rises in the cycle after the go write and falls in the cycle after the last request is acknowledged. A go write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register selector |
| wr_data_i | input | 8 | Register write data |
| width_i | input | 7 | Screen width in 8-pixel units |
| height_i | input | 10 | Screen height in lines |
| hires_i | input | 1 | 1 selects 15-bit addressing, 0 selects 14-bit |
| op_req_o | output | 1 | Raster request valid |
| op_addr_o | output | 15 | Byte address of the request |
| op_mask_o | output | 8 | Write-protect mask, 0 = writable |
| op_ack_i | input | 1 | Raster request accepted |
| busy_o | output | 1 | Line in progress |

## Verification
A wrong slope, step direction or accumulator value shows at op_addr_o within the first one or two requests after the rows diverge. Endpoints are swept in every octant and direction on a small screen to catch it. A dash pattern that has lost its rotation or its alignment shows in op_mask_o at the next plotted byte. The near-exhaustive sweep uses a different pattern per line to expose this. Errors in batching or clipping change the number of requests, and that count is compared per line. Acknowledge delays of zero to two cycles check that a stalled request holds its address and mask.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int unsigned XW  = 10;
  localparam int unsigned YW  = 9;
  localparam int unsigned WW  = 7;
  localparam int unsigned HW  = 10;
  localparam int unsigned AW  = 15;
  localparam int unsigned LAW = 14;
  localparam int unsigned OFW = 14;
  localparam int unsigned PW  = 16;
  localparam int unsigned FW  = 15;

  typedef enum logic [3:0] {
    SEL_OFF_LO = 4'd0,  SEL_OFF_HI = 4'd1,
    SEL_PAT_LO = 4'd2,  SEL_PAT_HI = 4'd3,
    SEL_X0_LO  = 4'd4,  SEL_X0_HI  = 4'd5,
    SEL_Y0_LO  = 4'd6,  SEL_Y0_HI  = 4'd7,
    SEL_X1_LO  = 4'd8,  SEL_X1_HI  = 4'd9,
    SEL_Y1_LO  = 4'd10, SEL_Y1_HI  = 4'd11,
    SEL_GO     = 4'd15
  } sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_STEP, ST_FLUSH, ST_LAST
  } st_e;
endpackage

// File: rtl/dl_regs.sv
module dl_regs
  import dl_pkg::*;
#(
  parameter int unsigned XW_P  = XW,
  parameter int unsigned YW_P  = YW,
  parameter int unsigned OFW_P = OFW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [XW_P-1:0]  x0_o,
  output logic [XW_P-1:0]  x1_o,
  output logic [YW_P-1:0]  y0_o,
  output logic [YW_P-1:0]  y1_o,
  output logic [OFW_P-1:0] off_o,
  output logic [15:0]      pat_o,
  output logic             go_o
);
  localparam int unsigned XH = XW_P - 8;
  localparam int unsigned YH = YW_P - 8;
  localparam int unsigned OH = OFW_P - 9;

  logic [7:0]    x0_lo_q, x1_lo_q, y0_lo_q, y1_lo_q, off_lo_q, pat_lo_q, pat_hi_q;
  logic [XH-1:0] x0_hi_q, x1_hi_q;
  logic [YH-1:0] y0_hi_q, y1_hi_q;
  logic [OH-1:0] off_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x0_lo_q <= '0; x1_lo_q <= '0; y0_lo_q <= '0; y1_lo_q <= '0;
      x0_hi_q <= '0; x1_hi_q <= '0; y0_hi_q <= '0; y1_hi_q <= '0;
      off_lo_q <= '0; off_hi_q <= '0; pat_lo_q <= '0; pat_hi_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_OFF_LO: off_lo_q <= wr_data_i;
        SEL_OFF_HI: off_hi_q <= wr_data_i[OH-1:0];
        SEL_PAT_LO: pat_lo_q <= wr_data_i;
        SEL_PAT_HI: pat_hi_q <= wr_data_i;
        SEL_X0_LO:  x0_lo_q  <= wr_data_i;
        SEL_X0_HI:  x0_hi_q  <= wr_data_i[XH-1:0];
        SEL_Y0_LO:  y0_lo_q  <= wr_data_i;
        SEL_Y0_HI:  y0_hi_q  <= wr_data_i[YH-1:0];
        SEL_X1_LO:  x1_lo_q  <= wr_data_i;
        SEL_X1_HI:  x1_hi_q  <= wr_data_i[XH-1:0];
        SEL_Y1_LO:  y1_lo_q  <= wr_data_i;
        SEL_Y1_HI:  y1_hi_q  <= wr_data_i[YH-1:0];
        default: ;
      endcase
    end
  end

  assign x0_o  = {x0_hi_q, x0_lo_q};
  assign x1_o  = {x1_hi_q, x1_lo_q};
  assign y0_o  = {y0_hi_q, y0_lo_q};
  assign y1_o  = {y1_hi_q, y1_lo_q};
  assign off_o = {off_hi_q, off_lo_q, 1'b0};
  assign pat_o = {pat_hi_q, pat_lo_q};
  assign go_o  = wr_en_i && (wr_sel_i == SEL_GO);
endmodule

// File: rtl/dl_div.sv
module dl_div
  import dl_pkg::*;
#(
  parameter int unsigned NW_P = XW,
  parameter int unsigned FW_P = FW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic [NW_P-1:0] num_i,
  input  logic [NW_P-1:0] den_i,
  output logic            done_o,
  output logic [FW_P:0]   quot_o
);
  localparam int unsigned DW = NW_P + FW_P;
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0]   dvd_q, quo_q;
  logic [NW_P-1:0] rem_q, den_q;
  logic [CW-1:0]   cnt_q;
  logic            run_q, done_q;
  logic [NW_P:0]   trial;
  logic            fit;

  assign trial = {rem_q, dvd_q[DW-1]};
  assign fit   = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0; quo_q <= '0; rem_q <= '0; den_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= run_q && (cnt_q == CW'(1));
      if (go_i) begin
        dvd_q <= {num_i, {FW_P{1'b0}}};
        den_q <= den_i;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        dvd_q <= dvd_q << 1;
        rem_q <= fit ? NW_P'(trial - {1'b0, den_q}) : trial[NW_P-1:0];
        quo_q <= {quo_q[DW-2:0], fit};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) run_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q[FW_P:0];

  // slope never exceeds one full step when minor <= major
  assert_quot_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (quo_q <= DW'(1) << FW_P));
endmodule

// File: rtl/dl_walker.sv
module dl_walker
  import dl_pkg::*;
#(
  parameter int unsigned XW_P  = XW,
  parameter int unsigned YW_P  = YW,
  parameter int unsigned WW_P  = WW,
  parameter int unsigned HW_P  = HW,
  parameter int unsigned AW_P  = AW,
  parameter int unsigned LAW_P = LAW,
  parameter int unsigned OFW_P = OFW,
  parameter int unsigned FW_P  = FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [XW_P-1:0]  x0_i,
  input  logic [XW_P-1:0]  x1_i,
  input  logic [YW_P-1:0]  y0_i,
  input  logic [YW_P-1:0]  y1_i,
  input  logic [OFW_P-1:0] off_i,
  input  logic [15:0]      pat_i,
  input  logic [WW_P-1:0]  width_i,
  input  logic [HW_P-1:0]  height_i,
  input  logic             hires_i,
  output logic             div_go_o,
  output logic [XW_P-1:0]  div_num_o,
  output logic [XW_P-1:0]  div_den_o,
  input  logic             div_done_i,
  input  logic [FW_P:0]    div_quot_i,
  output logic             op_req_o,
  output logic [AW_P-1:0]  op_addr_o,
  output logic [7:0]       op_mask_o,
  input  logic             op_ack_i,
  output logic             busy_o
);
  localparam int unsigned QW = FW_P + 1;
  localparam int unsigned LW = YW_P + WW_P + 2;

  st_e             st_q;
  logic [XW_P-1:0] cx_q, rem_q;
  logic [YW_P-1:0] cy_q;
  logic            xneg_q, yneg_q, xmaj_q, hr_q;
  logic [QW-1:0]   frac_q, step_q;
  logic [15:0]     pat_q;
  logic [OFW_P-1:0] off_q;
  logic [WW_P-1:0] w_q;
  logic [HW_P-1:0] h_q;
  logic            pend_v_q, req_q;
  logic [AW_P-1:0] pend_a_q, oa_q;
  logic [7:0]      pend_m_q, om_q;

  // start-time geometry
  logic            dx_neg, dy_neg, xmaj;
  logic [XW_P-1:0] adx, ady, major, minor;
  assign dx_neg = x1_i < x0_i;
  assign dy_neg = y1_i < y0_i;
  assign adx    = dx_neg ? x0_i - x1_i : x1_i - x0_i;
  assign ady    = dy_neg ? XW_P'(y0_i - y1_i) : XW_P'(y1_i - y0_i);
  assign xmaj   = adx >= ady;
  assign major  = xmaj ? adx : ady;
  assign minor  = xmaj ? ady : adx;

  assign div_go_o  = (st_q == ST_IDLE) && go_i && (major != '0);
  assign div_num_o = minor;
  assign div_den_o = major;

  // current pixel
  logic [LW-1:0]   pix_lin;
  logic [AW_P-1:0] pix_addr;
  logic            off_scr, same;
  logic [7:0]      bit_sel, mask_base, mask_next;
  logic [QW-1:0]   frac_sum;
  logic            carry;

  assign pix_lin  = LW'(cy_q) * LW'(w_q) + LW'(cx_q[XW_P-1:3]) + LW'(off_q);
  assign pix_addr = hr_q ? pix_lin[AW_P-1:0]
                         : {{(AW_P-LAW_P){1'b0}}, pix_lin[LAW_P-1:0]};
  assign off_scr  = (32'(cx_q) >= 32'({w_q, 3'b000})) || (32'(cy_q) >= 32'(h_q));
  assign same     = !pend_v_q || (pix_addr == pend_a_q);
  assign bit_sel  = 8'h80 >> cx_q[2:0];
  assign mask_base = pend_v_q ? pend_m_q : 8'hFF;
  assign mask_next = pat_q[15] ? (mask_base & ~bit_sel) : mask_base;
  assign frac_sum = frac_q + step_q;
  assign carry    = frac_sum[FW_P];

  logic [XW_P-1:0] cx_step;
  logic [YW_P-1:0] cy_step;
  assign cx_step = xneg_q ? cx_q - XW_P'(1) : cx_q + XW_P'(1);
  assign cy_step = yneg_q ? cy_q - YW_P'(1) : cy_q + YW_P'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      cx_q <= '0; cy_q <= '0; rem_q <= '0;
      xneg_q <= 1'b0; yneg_q <= 1'b0; xmaj_q <= 1'b0; hr_q <= 1'b0;
      frac_q <= '0; step_q <= '0; pat_q <= '0; off_q <= '0; w_q <= '0; h_q <= '0;
      pend_v_q <= 1'b0; pend_a_q <= '0; pend_m_q <= 8'hFF;
      req_q <= 1'b0; oa_q <= '0; om_q <= 8'hFF;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          cx_q <= x0_i; cy_q <= y0_i;
          xneg_q <= dx_neg; yneg_q <= dy_neg; xmaj_q <= xmaj;
          rem_q <= major; frac_q <= '0; step_q <= '0;
          pat_q <= pat_i; off_q <= off_i; w_q <= width_i; h_q <= height_i;
          hr_q <= hires_i; pend_v_q <= 1'b0;
          st_q <= (major == '0) ? ST_STEP : ST_DIV;
        end
        ST_DIV: if (div_done_i) begin
          step_q <= div_quot_i;
          st_q   <= ST_STEP;
        end
        ST_STEP: begin
          if (off_scr) begin
            if (pend_v_q) begin
              req_q <= 1'b1; oa_q <= pend_a_q; om_q <= pend_m_q;
              pend_v_q <= 1'b0;
              st_q <= ST_LAST;
            end else begin
              st_q <= ST_IDLE;
            end
          end else if (!same) begin
            req_q <= 1'b1; oa_q <= pend_a_q; om_q <= pend_m_q;
            st_q <= ST_FLUSH;
          end else begin
            pat_q <= {pat_q[14:0], pat_q[15]};
            if (rem_q == '0) begin
              req_q <= 1'b1; oa_q <= pix_addr; om_q <= mask_next;
              pend_v_q <= 1'b0;
              st_q <= ST_LAST;
            end else begin
              pend_v_q <= 1'b1; pend_a_q <= pix_addr; pend_m_q <= mask_next;
              rem_q  <= rem_q - XW_P'(1);
              frac_q <= {1'b0, frac_sum[FW_P-1:0]};
              if (xmaj_q) begin
                cx_q <= cx_step;
                if (carry) cy_q <= cy_step;
              end else begin
                cy_q <= cy_step;
                if (carry) cx_q <= cx_step;
              end
            end
          end
        end
        ST_FLUSH: if (op_ack_i) begin
          req_q <= 1'b0; pend_v_q <= 1'b0;
          st_q <= ST_STEP;
        end
        ST_LAST: if (op_ack_i) begin
          req_q <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_req_o  = req_q;
  assign op_addr_o = oa_q;
  assign op_mask_o = om_q;
  assign busy_o    = st_q != ST_IDLE;

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !op_ack_i |=> req_q && $stable(oa_q) && $stable(om_q));
  assert_req_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && op_ack_i |=> !req_q);
  assert_req_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> busy_o);
  assert_low_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !hr_q |-> (oa_q[AW_P-1:LAW_P] == '0));
  assert_pat_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) && ($past(st_q) != ST_IDLE) |-> $countones(pat_q) == $countones($past(pat_q)));
endmodule

// File: rtl/dash_line_engine.sv
module dash_line_engine
  import dl_pkg::*;
#(
  parameter int unsigned XW_P  = XW,
  parameter int unsigned YW_P  = YW,
  parameter int unsigned WW_P  = WW,
  parameter int unsigned HW_P  = HW,
  parameter int unsigned AW_P  = AW,
  parameter int unsigned LAW_P = LAW,
  parameter int unsigned OFW_P = OFW,
  parameter int unsigned FW_P  = FW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_sel_i,
  input  logic [7:0]      wr_data_i,
  input  logic [WW_P-1:0] width_i,
  input  logic [HW_P-1:0] height_i,
  input  logic            hires_i,
  output logic            op_req_o,
  output logic [AW_P-1:0] op_addr_o,
  output logic [7:0]      op_mask_o,
  input  logic            op_ack_i,
  output logic            busy_o
);
  logic [XW_P-1:0]  x0, x1, dnum, dden;
  logic [YW_P-1:0]  y0, y1;
  logic [OFW_P-1:0] off;
  logic [15:0]      pat;
  logic             go, dgo, ddone;
  logic [FW_P:0]    dquot;

  dl_regs #(.XW_P(XW_P), .YW_P(YW_P), .OFW_P(OFW_P)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .x0_o(x0), .x1_o(x1), .y0_o(y0), .y1_o(y1),
    .off_o(off), .pat_o(pat), .go_o(go)
  );

  dl_div #(.NW_P(XW_P), .FW_P(FW_P)) u_div (
    .clk_i, .rst_ni, .go_i(dgo), .num_i(dnum), .den_i(dden),
    .done_o(ddone), .quot_o(dquot)
  );

  dl_walker #(
    .XW_P(XW_P), .YW_P(YW_P), .WW_P(WW_P), .HW_P(HW_P),
    .AW_P(AW_P), .LAW_P(LAW_P), .OFW_P(OFW_P), .FW_P(FW_P)
  ) u_walk (
    .clk_i, .rst_ni, .go_i(go),
    .x0_i(x0), .x1_i(x1), .y0_i(y0), .y1_i(y1),
    .off_i(off), .pat_i(pat),
    .width_i, .height_i, .hires_i,
    .div_go_o(dgo), .div_num_o(dnum), .div_den_o(dden),
    .div_done_i(ddone), .div_quot_i(dquot),
    .op_req_o, .op_addr_o, .op_mask_o, .op_ack_i, .busy_o
  );
endmodule

// File: tb/sim_dash_line_engine.sv
`timescale 1ns/1ps
module sim_dash_line_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [6:0]  width_i = 7'd4;
  logic [9:0]  height_i = 10'd12;
  logic        hires_i = 1'b1;
  logic        op_req_o;
  logic [14:0] op_addr_o;
  logic [7:0]  op_mask_o;
  logic        op_ack_i = 1'b0;
  logic        busy_o;

  always #4 clk_i = ~clk_i;

  dash_line_engine u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_a[1024], exp_m[1024], got_a[1024], got_m[1024];
  int n_exp, n_got, ack_dly, wcnt, hold_bad, busy_bad, ha, hm;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // raster responder
  always @(negedge clk_i) begin
    if (op_ack_i) op_ack_i = 1'b0;
    else if (op_req_o) begin
      if (wcnt == 0) begin ha = op_addr_o; hm = op_mask_o; end
      else if (op_addr_o != ha || op_mask_o != hm) hold_bad++;
      if (wcnt >= ack_dly) begin
        if (n_got < 1024) begin got_a[n_got] = op_addr_o; got_m[n_got] = op_mask_o; end
        n_got++;
        if (!busy_o) busy_bad++;
        op_ack_i = 1'b1;
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic push(input int a, input int m);
    exp_a[n_exp] = a; exp_m[n_exp] = m; n_exp++;
  endtask

  task automatic model(input int x0, input int y0, input int x1, input int y1,
                       input int wu, input int ht, input int off, input int pat, input bit hr);
    int ax, ay, sx, sy, major, minor, step, frac, rem, x, y, p, pa, pm, a;
    bit pv, xm;
    n_exp = 0;
    ax = (x1 > x0) ? x1 - x0 : x0 - x1;  ay = (y1 > y0) ? y1 - y0 : y0 - y1;
    sx = (x1 < x0) ? -1 : 1;             sy = (y1 < y0) ? -1 : 1;
    xm = ax >= ay;
    major = xm ? ax : ay;  minor = xm ? ay : ax;
    step = (major == 0) ? 0 : (minor * 32768) / major;
    x = x0; y = y0; frac = 0; rem = major; p = pat; pv = 0; pa = 0; pm = 255;
    forever begin
      if (x >= wu * 8 || y >= ht) break;
      a = (y * wu + x / 8 + off) & (hr ? 32'h7fff : 32'h3fff);
      if (pv && a != pa) begin push(pa, pm); pv = 0; end
      if (!pv) begin pv = 1; pa = a; pm = 255; end
      if (p[15]) pm = pm & ~(128 >> (x % 8));
      p = ((p << 1) | (p >> 15)) & 32'hffff;
      if (rem == 0) break;
      frac += step;
      if (xm) begin x += sx; if (frac >= 32768) begin y += sy; frac -= 32768; end end
      else    begin y += sy; if (frac >= 32768) begin x += sx; frac -= 32768; end end
      rem--;
    end
    if (pv) push(pa, pm);
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 4'(sel); wr_data_i = 8'(data);
  endtask

  task automatic run_raw(input int x0l, input int x0h, input int y0l, input int y0h,
                         input int x1l, input int x1h, input int y1l, input int y1h,
                         input int offl, input int offh, input int pat, input bit twice,
                         input string tc, input string ta);
    int x0, y0, x1, y1, off, t;
    x0 = ((x0h & 3) << 8) | x0l;  x1 = ((x1h & 3) << 8) | x1l;
    y0 = ((y0h & 1) << 8) | y0l;  y1 = ((y1h & 1) << 8) | y1l;
    off = ((offh & 31) << 9) | (offl << 1);
    model(x0, y0, x1, y1, width_i, height_i, off, pat, hires_i);
    n_got = 0; hold_bad = 0; busy_bad = 0; wcnt = 0;
    wr(0, offl); wr(1, offh); wr(2, pat & 255); wr(3, pat >> 8);
    wr(4, x0l); wr(5, x0h); wr(6, y0l); wr(7, y0h);
    wr(8, x1l); wr(9, x1h); wr(10, y1l); wr(11, y1h);
    wr(15, 0);
    @(negedge clk_i); wr_en_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after go", busy_o, 1);
    if (twice) begin wr(15, 0); @(negedge clk_i); wr_en_i = 1'b0; end
    t = 0;
    while (busy_o && t < 5000) begin @(negedge clk_i); t++; end
    chk(n_got == n_exp, tc, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_a[i] == exp_a[i], ta, got_a[i], exp_a[i]);
      chk(got_m[i] == exp_m[i], "R6 mask", got_m[i], exp_m[i]);
    end
    chk(hold_bad == 0, "R9 hold", hold_bad, 0);
    chk(busy_bad == 0, "R10 busy at ack", busy_bad, 0);
    repeat (3) @(negedge clk_i);
    chk(op_req_o == 1'b0 && n_got == n_exp, "R10 go while busy ignored", n_got, n_exp);
  endtask

  task automatic run_line(input int x0, input int y0, input int x1, input int y1,
                          input int pat, input string tc, input string ta);
    run_raw(x0 & 255, x0 >> 8, y0 & 255, y0 >> 8, x1 & 255, x1 >> 8, y1 & 255, y1 >> 8,
            0, 0, pat, 1'b0, tc, ta);
  endtask

  initial begin
    int px[4] = '{0, 5, 17, 31};
    int py[3] = '{0, 4, 11};
    int pats[4] = '{32'hFFFF, 32'hA5C3, 32'h0001, 32'h7E18};
    int idx;
    ack_dly = 0;
    #1;
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(op_req_o == 1'b0, "R1 req reset", op_req_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && op_req_o == 1'b0, "R1 idle after reset", busy_o, 0);
    // R1: go with untouched registers -> single pixel at 0, pattern 0
    model(0, 0, 0, 0, 4, 12, 0, 0, 1'b1);
    n_got = 0; wcnt = 0;
    wr(15, 0); @(negedge clk_i); wr_en_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(n_got == 1 && got_a[0] == 0 && got_m[0] == 255, "R1 reset registers", got_m[0], 255);

    // R5/R6/R7: near-exhaustive endpoint sweep
    idx = 0;
    foreach (px[a]) foreach (py[b]) foreach (px[c]) foreach (py[d]) begin
      ack_dly = idx % 3;
      run_line(px[a], py[b], px[c], py[d], pats[idx % 4], "R7 op count", "R5 addr");
      idx++;
    end

    // R8: clipping at right and bottom edges, and start off screen
    ack_dly = 1;
    run_line(20, 2, 45, 6, 16'hFFFF, "R8 clip x count", "R8 clip x addr");
    run_line(3, 1, 9, 20, 16'hF0F0, "R8 clip y count", "R8 clip y addr");
    run_line(40, 1, 2, 3, 16'hFFFF, "R8 off-screen start", "R8 addr");

    // R3: offset encoding
    run_raw(9, 0, 3, 0, 26, 0, 7, 0, 8'h5A, 8'h03, 16'hCCCC, 1'b0, "R3 count", "R3 offset addr");

    // R4: low resolution wraps at 14 bits, high does not
    hires_i = 1'b0;
    run_raw(0, 0, 2, 0, 31, 0, 10, 0, 8'hFF, 8'h1F, 16'hFFFF, 1'b0, "R4 count", "R4 lowres addr");
    hires_i = 1'b1;
    run_raw(0, 0, 2, 0, 31, 0, 10, 0, 8'hFF, 8'h1F, 16'hFFFF, 1'b0, "R4 count", "R4 hires addr");

    // R2: high bytes keep only their coordinate bits; wide screen
    width_i = 7'd127; height_i = 10'd600;
    run_raw(8'h10, 8'hFD, 8'h05, 8'hFE, 8'h24, 8'hFD, 8'h09, 8'hFE, 0, 0, 16'h8421,
            1'b0, "R2 count", "R2 addr");
    run_raw(8'h02, 8'h00, 8'h04, 8'hFF, 8'h08, 8'h00, 8'h00, 8'hFF, 0, 0, 16'hFFFF,
            1'b0, "R2 count y", "R2 addr y");

    // R10: second go while busy has no effect
    width_i = 7'd4; height_i = 10'd12; ack_dly = 2;
    run_raw(1, 0, 1, 0, 30, 0, 9, 0, 0, 0, 16'hFF00, 1'b1, "R10 count", "R10 addr");
    // R6: zero pattern leaves every mask closed
    run_line(0, 0, 31, 3, 16'h0000, "R6 count", "R6 addr");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule